// File: doc/BRIEF.md
# Fused High/Low Multiply Issue

This block sits at the issue stage of a pipeline with a two-entry issue window. Slot 0 holds the older instruction and slot 1 the younger. Each slot can hold one multiply, which asks for either the low or the high half of the unsigned product of two register operands. The block looks at both slots in every cycle and checks whether they form a low-half request followed directly by a high-half request that reads the same two source registers.

When the slots form such a pair, one multiplication is issued and both slots are consumed together. One cycle later, the first write port puts the low half of the double-width product into the older instruction's destination register. In the same cycle, the second write port puts the high half into the younger instruction's destination register. When the slots do not form a pair, the older multiply issues on its own and returns only the half it asked for. The younger slot is held until the next cycle.

The instruction encoding does not change. The pairing is found purely from the decoded fields. Operand values are taken from slot 0, and slot 1 carries no values, because a fused partner reads the same registers. Register file contents and all hazard checks other than the pair test belong to the surrounding pipeline.

Top module: `fused_mul_issue`

## Requirements
- R1: While reset is high, and in the first cycle after it, neither write port asserts its enable, and no slot is reported as consumed while reset is high.
- R2: A pair is recognised when both slots are valid, slot 0 asks for the low half (half bit 0), slot 1 asks for the high half (half bit 1), both source indices match position by position, and slot 0's destination differs from both sources. In that cycle `s0_take` and `s1_take` are both 1 and `s1_hold` is 0.
- R3: One cycle after a pair issues, port A writes bits [XLEN-1:0] of the unsigned product to slot 0's destination, and port B writes bits [2*XLEN-1:XLEN] to slot 1's destination, with both enables high in the same cycle.
- R4: The source indices are matched in order. If the two sources are swapped between the slots, there is no fusion, only slot 0 issues, and slot 1 is held.
- R5: If slot 0's destination equals either of its sources, there is no fusion, even when every other pair condition holds.
- R6: A lone low-half multiply in slot 0 issues and, one cycle later, writes only the low half on port A, with port B idle.
- R7: A lone high-half multiply in slot 0 issues and, one cycle later, writes only the high half on port A, with port B idle. A high-half request followed by a low-half request is never fused.
- R8: A write port is enabled exactly in the cycle after an issue. With no valid slot 0 there is no take, and both ports are idle one cycle later.
- R9: `s1_take` is never 1 without `s0_take`. `s1_hold` is 1 exactly when slot 1 is valid and not consumed.
- R10: The operands are unsigned. All-ones operands give a high half of all-ones minus one and a low half of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_vld | input | 1 | Slot 0 holds a multiply |
| s0_hi | input | 1 | Slot 0 half select: 0 for low, 1 for high |
| s0_ra | input | RIDX | Slot 0 first source index |
| s0_rb | input | RIDX | Slot 0 second source index |
| s0_rd | input | RIDX | Slot 0 destination index |
| s0_va | input | XLEN | Value of the first source |
| s0_vb | input | XLEN | Value of the second source |
| s1_vld | input | 1 | Slot 1 holds a multiply |
| s1_hi | input | 1 | Slot 1 half select: 0 for low, 1 for high |
| s1_ra | input | RIDX | Slot 1 first source index |
| s1_rb | input | RIDX | Slot 1 second source index |
| s1_rd | input | RIDX | Slot 1 destination index |
| s0_take | output | 1 | Slot 0 consumed this cycle |
| s1_take | output | 1 | Slot 1 consumed this cycle (fused) |
| s1_hold | output | 1 | Slot 1 valid but held this cycle |
| wa_en | output | 1 | Write port A enable |
| wa_idx | output | RIDX | Write port A destination |
| wa_val | output | XLEN | Write port A data |
| wb_en | output | 1 | Write port B enable |
| wb_idx | output | RIDX | Write port B destination |
| wb_val | output | XLEN | Write port B data |

## Verification
Two things can happen in the same cycle. First, a writeback from the previous issue can appear on the ports while a new pair decision is being made. Second, a fused pair drives both write ports in a single cycle. The bench provokes both with back-to-back fused pairs and with lone issues right after a fused one, including a pair with all-ones operands. A behavioural model predicts the take, hold and write port values for every cycle, and the bench compares them at the falling edge. The model also covers the cases where the pair test must reject: swapped sources, a destination that clashes with a source, and a high-half request followed by a low-half request.

// File: rtl/fmi_pkg.sv
package fmi_pkg;
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/fmi_pair_detect.sv
module fmi_pair_detect #(
    parameter int RIDX = 5
) (
    input  logic            rst,
    input  logic            v0,
    input  logic            h0,
    input  logic [RIDX-1:0] ra0,
    input  logic [RIDX-1:0] rb0,
    input  logic [RIDX-1:0] rd0,
    input  logic            v1,
    input  logic            h1,
    input  logic [RIDX-1:0] ra1,
    input  logic [RIDX-1:0] rb1,
    output logic            take0,
    output logic            take1,
    output logic            hold1
);
    import fmi_pkg::*;

    logic kinds_ok;
    logic srcs_ok;
    logic dest_ok;
    logic pair_ok;

    always_comb begin
        kinds_ok = (half_e'(h0) == HALF_LO) && (half_e'(h1) == HALF_HI);
        srcs_ok  = (ra0 == ra1) && (rb0 == rb1);
        dest_ok  = (rd0 != ra0) && (rd0 != rb0);
        pair_ok  = v0 && v1 && kinds_ok && srcs_ok && dest_ok;
        take0    = !rst && v0;
        take1    = !rst && pair_ok;
        hold1    = !rst && v1 && !pair_ok;
    end
endmodule

// File: rtl/fmi_mult_stage.sv
module fmi_mult_stage #(
    parameter int XLEN = 32,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic            fuse,
    input  logic            want_hi,
    input  logic [RIDX-1:0] dst_lo,
    input  logic [RIDX-1:0] dst_hi,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            wa_en,
    output logic [RIDX-1:0] wa_idx,
    output logic [XLEN-1:0] wa_val,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_val
);
    localparam int PW = 2 * XLEN;

    typedef struct packed {
        logic            a_en;
        logic [RIDX-1:0] a_idx;
        logic [XLEN-1:0] a_val;
        logic            b_en;
        logic [RIDX-1:0] b_idx;
        logic [XLEN-1:0] b_val;
    } wr_st_t;

    wr_st_t          st_d, st_q;
    logic [PW-1:0]   prod;

    always_comb begin
        prod       = PW'(opa) * PW'(opb);
        st_d       = '0;
        st_d.a_en  = issue;
        st_d.a_idx = dst_lo;
        if (fuse) begin
            st_d.a_val = prod[XLEN-1:0];
            st_d.b_en  = 1'b1;
            st_d.b_idx = dst_hi;
            st_d.b_val = prod[PW-1:XLEN];
        end else begin
            st_d.a_val = want_hi ? prod[PW-1:XLEN] : prod[XLEN-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wa_en  = st_q.a_en;
    assign wa_idx = st_q.a_idx;
    assign wa_val = st_q.a_val;
    assign wb_en  = st_q.b_en;
    assign wb_idx = st_q.b_idx;
    assign wb_val = st_q.b_val;

    p_issue_writes_r8: assert property (@(posedge clk) disable iff (rst)
        issue |=> wa_en);
    p_no_issue_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !issue |=> (!wa_en && !wb_en));
    p_fuse_both_ports_r3: assert property (@(posedge clk) disable iff (rst)
        fuse |=> (wa_en && wb_en));
endmodule

// File: rtl/fused_mul_issue.sv
module fused_mul_issue #(
    parameter int XLEN = 32,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            s0_vld,
    input  logic            s0_hi,
    input  logic [RIDX-1:0] s0_ra,
    input  logic [RIDX-1:0] s0_rb,
    input  logic [RIDX-1:0] s0_rd,
    input  logic [XLEN-1:0] s0_va,
    input  logic [XLEN-1:0] s0_vb,
    input  logic            s1_vld,
    input  logic            s1_hi,
    input  logic [RIDX-1:0] s1_ra,
    input  logic [RIDX-1:0] s1_rb,
    input  logic [RIDX-1:0] s1_rd,
    output logic            s0_take,
    output logic            s1_take,
    output logic            s1_hold,
    output logic            wa_en,
    output logic [RIDX-1:0] wa_idx,
    output logic [XLEN-1:0] wa_val,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_val
);
    fmi_pair_detect #(.RIDX(RIDX)) u_detect (
        .rst   (rst),
        .v0    (s0_vld),
        .h0    (s0_hi),
        .ra0   (s0_ra),
        .rb0   (s0_rb),
        .rd0   (s0_rd),
        .v1    (s1_vld),
        .h1    (s1_hi),
        .ra1   (s1_ra),
        .rb1   (s1_rb),
        .take0 (s0_take),
        .take1 (s1_take),
        .hold1 (s1_hold)
    );

    fmi_mult_stage #(.XLEN(XLEN), .RIDX(RIDX)) u_mult (
        .clk     (clk),
        .rst     (rst),
        .issue   (s0_take),
        .fuse    (s1_take),
        .want_hi (s0_hi),
        .dst_lo  (s0_rd),
        .dst_hi  (s1_rd),
        .opa     (s0_va),
        .opb     (s0_vb),
        .wa_en   (wa_en),
        .wa_idx  (wa_idx),
        .wa_val  (wa_val),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_val  (wb_val)
    );

    p_slot1_after_slot0_r9: assert property (@(posedge clk) disable iff (rst)
        s1_take |-> s0_take);
    p_take_hold_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(s1_take && s1_hold));
    p_pair_no_clash_r5: assert property (@(posedge clk) disable iff (rst)
        s1_take |-> (s0_rd != s0_ra && s0_rd != s0_rb));
    p_pair_order_r4: assert property (@(posedge clk) disable iff (rst)
        s1_take |-> (s0_ra == s1_ra && s0_rb == s1_rb && !s0_hi && s1_hi));
    p_full_product_r3: assert property (@(posedge clk) disable iff (rst)
        s1_take |=> ({wb_val, wa_val} == (2*XLEN)'($past(s0_va)) * (2*XLEN)'($past(s0_vb))));
    p_port_b_needs_a_r3: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wa_en);
endmodule

// File: tb/fused_mul_issue_bench.sv
`timescale 1ns/1ps
module fused_mul_issue_bench;
    localparam int XLEN = 32;
    localparam int RIDX = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s0_vld = 0, s0_hi = 0, s1_vld = 0, s1_hi = 0;
    logic [RIDX-1:0] s0_ra = 0, s0_rb = 0, s0_rd = 0, s1_ra = 0, s1_rb = 0, s1_rd = 0;
    logic [XLEN-1:0] s0_va = 0, s0_vb = 0;
    logic s0_take, s1_take, s1_hold, wa_en, wb_en;
    logic [RIDX-1:0] wa_idx, wb_idx;
    logic [XLEN-1:0] wa_val, wb_val;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic            p_aen = 0, p_ben = 0;
    logic [RIDX-1:0] p_aidx = 0, p_bidx = 0;
    logic [XLEN-1:0] p_aval = 0, p_bval = 0;

    always #2 clk = ~clk;

    fused_mul_issue #(.XLEN(XLEN), .RIDX(RIDX)) u_fused_mul_issue (.*);

    task automatic chk(input string tag, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag,
                        input logic v0, input logic h0, input int ra0, input int rb0, input int rd0,
                        input logic [XLEN-1:0] va, input logic [XLEN-1:0] vb,
                        input logic v1, input logic h1, input int ra1, input int rb1, input int rd1);
        logic pair;
        logic [2*XLEN-1:0] prod;
        s0_vld = v0; s0_hi = h0; s0_ra = RIDX'(ra0); s0_rb = RIDX'(rb0); s0_rd = RIDX'(rd0);
        s0_va = va; s0_vb = vb;
        s1_vld = v1; s1_hi = h1; s1_ra = RIDX'(ra1); s1_rb = RIDX'(rb1); s1_rd = RIDX'(rd1);
        @(negedge clk);
        pair = v0 && v1 && !h0 && h1 && ra0 == ra1 && rb0 == rb1 && rd0 != ra0 && rd0 != rb0;
        prod = {{XLEN{1'b0}}, va} * {{XLEN{1'b0}}, vb};
        chk(tag, "s0_take", XLEN'(s0_take), XLEN'(v0));
        chk(tag, "s1_take", XLEN'(s1_take), XLEN'(pair));
        chk(tag, "s1_hold", XLEN'(s1_hold), XLEN'(v1 && !pair));
        chk(tag, "wa_en", XLEN'(wa_en), XLEN'(p_aen));
        chk(tag, "wb_en", XLEN'(wb_en), XLEN'(p_ben));
        if (p_aen) begin
            chk(tag, "wa_idx", XLEN'(wa_idx), XLEN'(p_aidx));
            chk(tag, "wa_val", wa_val, p_aval);
        end
        if (p_ben) begin
            chk(tag, "wb_idx", XLEN'(wb_idx), XLEN'(p_bidx));
            chk(tag, "wb_val", wb_val, p_bval);
        end
        p_aen = v0; p_aidx = RIDX'(rd0);
        p_aval = (h0 && !pair) ? prod[2*XLEN-1:XLEN] : prod[XLEN-1:0];
        p_ben = pair; p_bidx = RIDX'(rd1); p_bval = prod[2*XLEN-1:XLEN];
        @(posedge clk);
        #1;
    endtask

    initial begin
        s0_vld = 1; s1_vld = 1; s1_hi = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset wa_en", XLEN'(wa_en), 0);
        chk("R1", "reset wb_en", XLEN'(wb_en), 0);
        chk("R1", "reset s0_take", XLEN'(s0_take), 0);
        chk("R1", "reset s1_take", XLEN'(s1_take), 0);
        rst = 1'b0;
        // R2 R3: fused pair, then fused pair back to back
        step("R2", 1, 0, 3, 4, 7, 32'h1234_5678, 32'h9abc_def0, 1, 1, 3, 4, 8);
        step("R3", 1, 0, 5, 6, 9, 32'hdead_beef, 32'h0000_0010, 1, 1, 5, 6, 10);
        // R4: swapped sources
        step("R4", 1, 0, 1, 2, 11, 32'h0001_0000, 32'h0003_0000, 1, 1, 2, 1, 12);
        // R5: destination clash with a source
        step("R5", 1, 0, 1, 2, 2, 32'hffff_0000, 32'h0001_0001, 1, 1, 1, 2, 13);
        step("R5", 1, 0, 1, 2, 1, 32'h8000_0001, 32'h8000_0003, 1, 1, 1, 2, 13);
        // R6: lone low half
        step("R6", 1, 0, 7, 8, 14, 32'hcafe_f00d, 32'h1357_9bdf, 0, 0, 0, 0, 0);
        // R7: lone high half, then high followed by low is not fused
        step("R7", 1, 1, 7, 8, 15, 32'hcafe_f00d, 32'h1357_9bdf, 0, 0, 0, 0, 0);
        step("R7", 1, 1, 3, 4, 16, 32'h7777_7777, 32'h3333_3333, 1, 0, 3, 4, 17);
        // R8: idle cycle after an issue, then idle again
        step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3, 4, 18);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10: all-ones operands, fused
        step("R10", 1, 0, 20, 21, 22, 32'hffff_ffff, 32'hffff_ffff, 1, 1, 20, 21, 23);
        // R9: lone issue straight after a fused pair with a held slot 1
        step("R9", 1, 0, 9, 9, 24, 32'h0000_0003, 32'h0000_0005, 1, 1, 9, 8, 25);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule